// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block translates 32-bit virtual addresses to physical addresses through a small, fully associative table. Each table slot covers two neighbouring 4 KiB virtual pages, an even one and an odd one. The slot holds one shared tag. It also holds two physical frame numbers, each with its own valid and dirty flag. A slot may be marked global, so that it matches whatever the current address-space identifier is. Otherwise it matches only the 8-bit identifier stored with it. Each slot also stores an exclusive upper address bound.

The requester presents an address, a write flag and the current identifier together with a request strobe. One clock later the block returns a result code, the physical address and the read and write permissions. Software fills slots through a simple indexed write port, one slot per strobe. Choosing a victim slot and handling misses are left to the surrounding logic.

Top module: `tlb_pair_lookup`

## Requirements
- R1: A synchronous active-high reset clears every slot and drops `rsp_valid`. After reset, and until a slot is loaded, every lookup returns the miss code.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. The result fields belong to the request captured at that edge.
- R3: A slot matches only when all three of these hold: `req_vaddr[31:13]` equals its stored pair tag; its global flag is set or its stored identifier equals `cur_asid`; and `req_vaddr` is strictly below its stored upper bound.
- R4: Within a matching slot, `req_vaddr[12]`=0 selects the even half and `req_vaddr[12]`=1 selects the odd half. The frame, valid flag and dirty flag all come from the selected half.
- R5: When the selected half's valid flag is clear, the result code is 2 (invalid page), whatever the access type.
- R6: On a valid half, a read gives code 0 (hit). A write gives code 0 only when the dirty flag is set; otherwise it gives code 3 (page not writable).
- R7: On code 0, `rsp_paddr` = {selected frame, `req_vaddr[11:0]`}, `rsp_can_read`=1, and `rsp_can_write` equals the selected dirty flag.
- R8: When no slot matches, the code is 1 (miss). On any code other than 0, `rsp_paddr`, `rsp_can_read` and `rsp_can_write` are zero.
- R9: When several slots match, the slot with the lowest index decides the result.
- R10: With `wr_en` high at a clock edge, slot `wr_idx` takes all the written fields at that edge. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load strobe for one slot |
| wr_idx | input | $clog2(ENTRIES) | Slot to load |
| wr_vpn2 | input | 19 | Pair tag (virtual address bits 31..13) |
| wr_asid | input | 8 | Address-space identifier of the slot |
| wr_global | input | 1 | Match regardless of identifier |
| wr_limit | input | 32 | Exclusive upper virtual-address bound |
| wr_pfn_even | input | 20 | Frame number for the even page |
| wr_valid_even | input | 1 | Even page valid |
| wr_dirty_even | input | 1 | Even page writable |
| wr_pfn_odd | input | 20 | Frame number for the odd page |
| wr_valid_odd | input | 1 | Odd page valid |
| wr_dirty_odd | input | 1 | Odd page writable |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = store access, 0 = load access |
| cur_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_code | output | 2 | 0 hit, 1 miss, 2 invalid page, 3 not writable |
| rsp_paddr | output | 32 | Translated physical address (zero unless hit) |
| rsp_can_read | output | 1 | Read permission granted |
| rsp_can_write | output | 1 | Write permission granted |

## Verification
Every lookup result is due exactly one clock after its request edge, because a single output register sits after the combinational match and selection. The bench drives a request on a falling edge and works out the expected result from its own table model as it stands before that rising edge. It then compares all response ports on the following falling edge. A slot load takes effect at the same rising edge, so the model applies the load only after the expected value for that cycle has been fixed. This keeps the check for a lookup in the same cycle as a load (R10) on the old contents. On cycles with no request, the bench checks that `rsp_valid` stays low.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;

    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN2_W    = VA_W - PAGE_BITS - 1;
    localparam int ASID_W    = 8;
    localparam int PFN_W     = 20;
    localparam int PA_W      = PFN_W + PAGE_BITS;

    typedef enum logic [1:0] {
        RES_HIT      = 2'd0,
        RES_MISS     = 2'd1,
        RES_INVALID  = 2'd2,
        RES_MODIFIED = 2'd3
    } tlb_res_e;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [PFN_W-1:0] pfn;
    } tlb_half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [VA_W-1:0]   limit;
        tlb_half_t         even;
        tlb_half_t         odd;
    } tlb_entry_t;

    // Outcome of a lookup given whether any slot matched and the chosen half.
    function automatic tlb_res_e classify(input logic matched,
                                          input tlb_half_t half,
                                          input logic is_write);
        tlb_res_e r;
        if (!matched)
            r = RES_MISS;
        else if (!half.valid)
            r = RES_INVALID;
        else if (is_write && !half.dirty)
            r = RES_MODIFIED;
        else
            r = RES_HIT;
        return r;
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pair_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlb_entry_t                wr_entry,
    output tlb_entry_t [ENTRIES-1:0]  ent_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_entry;
        end
    end

    // R10: a load lands in the addressed slot at the strobe edge
    p_load_lands_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/tlb_match_vec.sv
module tlb_match_vec
    import tlb_pair_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tlb_entry_t [ENTRIES-1:0] ent,
    input  logic [VA_W-1:0]          vaddr,
    input  logic [ASID_W-1:0]        asid,
    output logic [ENTRIES-1:0]       match
);

    localparam int TAG_LSB = PAGE_BITS + 1;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic tag_eq;
        logic id_ok;
        logic in_range;
        always_comb begin
            tag_eq   = (ent[i].vpn2 == vaddr[VA_W-1:TAG_LSB]);
            id_ok    = ent[i].glob || (ent[i].asid == asid);
            in_range = (vaddr < ent[i].limit);
            match[i] = tag_eq && id_ok && in_range;
        end
    end

endmodule

// File: rtl/tlb_low_first.sv
module tlb_low_first #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] match,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [ENTRIES-1:0] grant
);

    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                any   = 1'b1;
                idx   = IDX_W'(i);
                grant = ENTRIES'(1) << i;
            end
        end
    end

    // R9: at most one winner, and it must be a matching slot
    p_single_winner_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~match) == '0));

    // R9: nothing below the winner may match
    p_lowest_wins_r9: assert property (@(posedge clk) disable iff (rst)
        any |-> ((match & (grant - ENTRIES'(1))) == '0));

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
    import tlb_pair_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
    input  logic [18:0]                 wr_vpn2,
    input  logic [7:0]                  wr_asid,
    input  logic                        wr_global,
    input  logic [31:0]                 wr_limit,
    input  logic [19:0]                 wr_pfn_even,
    input  logic                        wr_valid_even,
    input  logic                        wr_dirty_even,
    input  logic [19:0]                 wr_pfn_odd,
    input  logic                        wr_valid_odd,
    input  logic                        wr_dirty_odd,
    input  logic                        req_valid,
    input  logic [31:0]                 req_vaddr,
    input  logic                        req_write,
    input  logic [7:0]                  cur_asid,
    output logic                        rsp_valid,
    output logic [1:0]                  rsp_code,
    output logic [31:0]                 rsp_paddr,
    output logic                        rsp_can_read,
    output logic                        rsp_can_write
);

    localparam int IDX_W = $clog2(ENTRIES);

    tlb_entry_t               wr_entry;
    tlb_entry_t [ENTRIES-1:0] ent_q;
    logic [ENTRIES-1:0]       match;
    logic [ENTRIES-1:0]       grant;
    logic                     any_hit;
    logic [IDX_W-1:0]         win_idx;

    always_comb begin
        wr_entry.vpn2       = wr_vpn2;
        wr_entry.asid       = wr_asid;
        wr_entry.glob       = wr_global;
        wr_entry.limit      = wr_limit;
        wr_entry.even.pfn   = wr_pfn_even;
        wr_entry.even.valid = wr_valid_even;
        wr_entry.even.dirty = wr_dirty_even;
        wr_entry.odd.pfn    = wr_pfn_odd;
        wr_entry.odd.valid  = wr_valid_odd;
        wr_entry.odd.dirty  = wr_dirty_odd;
    end

    tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .ent_q    (ent_q)
    );

    tlb_match_vec #(.ENTRIES(ENTRIES)) u_match (
        .ent   (ent_q),
        .vaddr (req_vaddr),
        .asid  (cur_asid),
        .match (match)
    );

    tlb_low_first #(.ENTRIES(ENTRIES)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .match (match),
        .any   (any_hit),
        .idx   (win_idx),
        .grant (grant)
    );

    // Selection of the winning slot's half and the next response.
    tlb_entry_t       win_ent;
    tlb_half_t        half;
    tlb_res_e         code_d;
    logic             ok_d;
    logic [PA_W-1:0]  paddr_d;

    always_comb begin
        win_ent = ent_q[win_idx];
        half    = req_vaddr[PAGE_BITS] ? win_ent.odd : win_ent.even;
        code_d  = classify(any_hit, half, req_write);
        ok_d    = (code_d == RES_HIT);
        paddr_d = ok_d ? {half.pfn, req_vaddr[PAGE_BITS-1:0]} : '0;
    end

    tlb_res_e code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            code_q        <= RES_MISS;
            rsp_paddr     <= '0;
            rsp_can_read  <= 1'b0;
            rsp_can_write <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                code_q        <= code_d;
                rsp_paddr     <= paddr_d;
                rsp_can_read  <= ok_d;
                rsp_can_write <= ok_d && half.dirty;
            end
        end
    end

    assign rsp_code = code_q;

    // R2: response strobe trails the request strobe by one cycle
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8: non-hit results carry no address and no permission
    p_nonhit_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'd0) |->
            (rsp_paddr == '0 && !rsp_can_read && !rsp_can_write));

    // R7: a hit keeps the page offset of the captured request and grants read
    p_offset_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && code_d == RES_HIT) |=>
            (rsp_paddr[11:0] == $past(req_vaddr[11:0]) && rsp_can_read));

    // R6: a granted write never reports a write-denied hit
    p_store_needs_dirty_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd3) |-> !rsp_can_write);

endmodule

// File: tb/tlb_pair_lookup_tb_top.sv
module tlb_pair_lookup_tb_top;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [18:0] wr_vpn2;
    logic [7:0]  wr_asid;
    logic        wr_global;
    logic [31:0] wr_limit;
    logic [19:0] wr_pfn_even;
    logic        wr_valid_even;
    logic        wr_dirty_even;
    logic [19:0] wr_pfn_odd;
    logic        wr_valid_odd;
    logic        wr_dirty_odd;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_write;
    logic [7:0]  cur_asid;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_paddr;
    logic        rsp_can_read;
    logic        rsp_can_write;

    always #4 clk = ~clk;

    tlb_pair_lookup #(.ENTRIES(N)) dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
        .wr_global(wr_global), .wr_limit(wr_limit),
        .wr_pfn_even(wr_pfn_even), .wr_valid_even(wr_valid_even),
        .wr_dirty_even(wr_dirty_even),
        .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd),
        .wr_dirty_odd(wr_dirty_odd),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .cur_asid(cur_asid),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
        .rsp_can_read(rsp_can_read), .rsp_can_write(rsp_can_write)
    );

    // Behavioural table model
    int unsigned m_tag   [N];
    int unsigned m_id    [N];
    bit          m_glob  [N];
    longint      m_lim   [N];
    int unsigned m_pfn   [N][2];
    bit          m_v     [N][2];
    bit          m_d     [N][2];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_tag[i] = 0; m_id[i] = 0; m_glob[i] = 0; m_lim[i] = 0;
            for (int h = 0; h < 2; h++) begin
                m_pfn[i][h] = 0; m_v[i][h] = 0; m_d[i][h] = 0;
            end
        end
    endtask

    // Expected result from the table as it stands now.
    task automatic ref_lookup(input logic [31:0] va, input bit wr,
                              input logic [7:0] id,
                              output int code, output longint pa,
                              output bit cr, output bit cw);
        int hit = -1;
        for (int i = 0; i < N; i++) begin
            if (hit < 0 && m_tag[i] == int'(va >> 13) &&
                (m_glob[i] || m_id[i] == int'(id)) &&
                longint'(va) < m_lim[i])
                hit = i;
        end
        code = 1; pa = 0; cr = 0; cw = 0;
        if (hit >= 0) begin
            int h = int'(va[12]);
            if (!m_v[hit][h]) code = 2;
            else if (wr && !m_d[hit][h]) code = 3;
            else begin
                code = 0;
                pa = longint'(m_pfn[hit][h]) * 4096 + longint'(va[11:0]);
                cr = 1;
                cw = m_d[hit][h];
            end
        end
    endtask

    // One clock: drive on falling edge, fix expectation, check on next fall.
    task automatic step(bit rq, logic [31:0] va, bit wr, logic [7:0] id, string tag);
        int     e_code;
        longint e_pa;
        bit     e_cr, e_cw;
        req_valid = rq; req_vaddr = va; req_write = wr; cur_asid = id;
        ref_lookup(va, wr, id, e_code, e_pa, e_cr, e_cw);
        @(posedge clk);
        #1;
        if (wr_en) begin
            int k = int'(wr_idx);
            m_tag[k] = wr_vpn2; m_id[k] = wr_asid; m_glob[k] = wr_global;
            m_lim[k] = longint'(wr_limit);
            m_pfn[k][0] = wr_pfn_even; m_v[k][0] = wr_valid_even; m_d[k][0] = wr_dirty_even;
            m_pfn[k][1] = wr_pfn_odd;  m_v[k][1] = wr_valid_odd;  m_d[k][1] = wr_dirty_odd;
        end
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b0;
        check({tag, " R2 strobe"}, rsp_valid, rq);
        if (rq) begin
            check({tag, " code"}, rsp_code, e_code);
            check({tag, " paddr"}, rsp_paddr, e_pa);
            check({tag, " can_read"}, rsp_can_read, e_cr);
            check({tag, " can_write"}, rsp_can_write, e_cw);
        end
    endtask

    task automatic set_load(int idx, logic [18:0] tag, logic [7:0] id, bit g,
                            logic [31:0] lim, logic [19:0] pe, bit ve, bit de,
                            logic [19:0] po, bit vo, bit dodd);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn2 = tag; wr_asid = id;
        wr_global = g; wr_limit = lim;
        wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
        wr_pfn_odd = po;  wr_valid_odd = vo;  wr_dirty_odd = dodd;
    endtask

    localparam logic [31:0] VA_A = 32'h1234_6000;  // bit 12 = 0
    localparam logic [31:0] VA_B = 32'h4000_0000;

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_vpn2 = '0; wr_asid = '0;
        wr_global = 1'b0; wr_limit = '0; wr_pfn_even = '0; wr_valid_even = 1'b0;
        wr_dirty_even = 1'b0; wr_pfn_odd = '0; wr_valid_odd = 1'b0;
        wr_dirty_odd = 1'b0; req_valid = 1'b0; req_vaddr = '0;
        req_write = 1'b0; cur_asid = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid low in reset", rsp_valid, 0);
        rst = 1'b0;

        // R1: empty table misses (R8 zeros)
        step(1, VA_A, 0, 8'h05, "R1/R8 empty");
        step(0, VA_A, 0, 8'h05, "R2 idle");

        // Slot 2: even valid+dirty, odd valid clean
        set_load(2, VA_A[31:13], 8'h05, 0, 32'hFFFF_FFFF,
                 20'h12345, 1, 1, 20'h6789A, 1, 0);
        step(0, 0, 0, 0, "R10 load");
        step(1, VA_A | 32'h0ABC, 0, 8'h05, "R4/R7 even read");
        step(1, VA_A | 32'h0ABC, 1, 8'h05, "R6/R7 even write");
        step(1, VA_A | 32'h1FFF, 0, 8'h05, "R4/R7 odd read");
        step(1, VA_A | 32'h1004, 1, 8'h05, "R6 odd write clean");
        step(1, VA_A, 0, 8'h06, "R3 id mismatch");
        step(1, VA_A + 32'h2000, 0, 8'h05, "R3 tag mismatch");

        // Slot 5: global, even invalid
        set_load(5, VA_B[31:13], 8'h77, 1, 32'hFFFF_FFFF,
                 20'hAAAAA, 0, 1, 20'hBBBBB, 1, 1);
        step(0, 0, 0, 0, "R10 load");
        step(1, VA_B | 32'h1010, 1, 8'h01, "R3 global odd write");
        step(1, VA_B | 32'h0010, 0, 8'h01, "R5 invalid read");
        step(1, VA_B | 32'h0010, 1, 8'h02, "R5 invalid write");

        // Slot 9: upper bound in the middle of the even page
        set_load(9, 19'h00100, 8'h05, 0, 32'h0020_0800,
                 20'h00011, 1, 1, 20'h00022, 1, 1);
        step(0, 0, 0, 0, "R10 load");
        step(1, 32'h0020_07FF, 0, 8'h05, "R3 below bound");
        step(1, 32'h0020_0800, 0, 8'h05, "R3 at bound");
        step(1, 32'h0020_1000, 0, 8'h05, "R3 above bound");

        // R9: slots 7 and 3 match the same address; slot 3 must win
        set_load(7, 19'h02000, 8'h09, 0, 32'hFFFF_FFFF,
                 20'h77777, 1, 1, 20'h77770, 1, 1);
        step(0, 0, 0, 0, "R10 load");
        set_load(3, 19'h02000, 8'h00, 1, 32'hFFFF_FFFF,
                 20'h33333, 1, 0, 20'h33330, 0, 0);
        step(0, 0, 0, 0, "R10 load");
        step(1, 32'h0400_0123, 0, 8'h09, "R9 low index read");
        step(1, 32'h0400_0123, 1, 8'h09, "R9 low index write");
        step(1, 32'h0400_1123, 0, 8'h09, "R9 low index odd");

        // R10: load slot 3 and look up in the same cycle -> old contents
        set_load(3, 19'h02000, 8'h00, 1, 32'hFFFF_FFFF,
                 20'h44444, 1, 1, 20'h44440, 1, 1);
        step(1, 32'h0400_0456, 1, 8'h09, "R10 same-cycle old");
        step(1, 32'h0400_0456, 1, 8'h09, "R10 after load new");

        // Back-to-back requests and idle gap
        step(1, VA_A | 32'h0001, 0, 8'h05, "R2 back-to-back a");
        step(1, VA_B | 32'h1002, 0, 8'h33, "R2 back-to-back b");
        step(0, VA_A, 0, 8'h05, "R2 idle gap");

        // R1: reset clears the table
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        check("R1 valid low after reset", rsp_valid, 0);
        step(1, VA_A, 0, 8'h05, "R1 cleared slot 2");
        step(1, VA_B | 32'h1000, 0, 8'h00, "R1 cleared slot 5");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule